// File: doc/BRIEF.md
# Serial Frame Boundary Lock Detector

This block takes a recovered serial stream, one bit per clock, and finds where each 12-bit frame begins. A frame has a start bit (1), ten payload bits, and a stop bit (0). The block tests one candidate bit offset per frame period. When the test fails during acquisition it moves the candidate forward by one bit. When the boundary shows up at the same offset for enough frames in a row, the block declares lock by pulling `lock_n` low. While locked it delivers one 10-bit word per frame with a one-cycle strobe. After enough consecutive frames without a boundary it drops lock and searches again.

While acquiring, the block watches for frames that contain two or more low-to-high transitions. Such a pattern can look like a frame boundary at the wrong offset. If two such frames arrive back to back, the lock declaration is held off. It stays held off until a frame with at most one rising transition arrives. Once the block is locked, these patterns are ignored.

The state machine has three states:
- `ST_HUNT`: no boundary candidate.
- `ST_CONFIRM`: 1 to 3 consecutive hits at the candidate offset.
- `ST_LOCKED`: lock declared.

The transitions are:
- `ST_HUNT` goes to `ST_CONFIRM` on a hit. On a miss it stays in `ST_HUNT` and slips one bit.
- `ST_CONFIRM` goes to `ST_HUNT` on a miss, with a slip. On a hit it counts up. On the fourth hit it goes to `ST_LOCKED`, unless the false-lock guard is active, in which case it stays in `ST_CONFIRM`.
- `ST_LOCKED` goes to `ST_HUNT` on the fourth consecutive miss, with a slip. A hit resets the miss count.

Top module: `frame_lock_detector`

## Requirements
- R1: While reset is low, `lock_n` is 1, `out_en` is 0, `word_vld` is 0 and `word_out` is 0.
- R2: A frame period is evaluated on the cycle its last bit is clocked in. It is a hit when the oldest of the 12 bits is 1 and the newest is 0. The payload is the 10 bits in between. The first payload bit received lands in `word_out[9]`.
- R3: After four consecutive hits at the same offset, `lock_n` goes low. In the same cycle, `word_vld` pulses with the payload of the fourth frame. This happens in the cycle after that frame's stop bit is clocked in.
- R4: A miss during acquisition clears the hit count, so four new consecutive hits are needed.
- R5: On a miss while unlocked, the next evaluation happens one cycle later. The candidate offset therefore advances by one bit. A stream that starts one bit late locks after four frames.
- R6: While locked, every frame period gives exactly one single-cycle `word_vld` pulse with that frame's payload. This includes missed frames that do not drop lock.
- R7: While locked, lock is dropped (`lock_n` goes to 1) after four consecutive missed frames. A hit clears the miss count.
- R8: `out_en` is the inverse of `lock_n`. While `lock_n` is 1, `word_vld` is 0 and `word_out` is 0.
- R9: When two consecutive frame periods each contain two or more rising transitions (a 0 followed by a 1), lock is not declared. Hits at the fourth position and beyond keep the count at three. One frame with at most one rising transition clears the block. A single such frame alone does not block lock.
- R10: Once locked, frames with many rising transitions do not disturb lock as long as the boundary holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock, one serial bit per rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| ser_bit | input | 1 | Recovered serial data bit |
| lock_n | output | 1 | Active-low lock indication |
| out_en | output | 1 | Output enable, high only while locked |
| word_vld | output | 1 | One-cycle strobe per delivered payload word |
| word_out | output | 10 | Payload word, zero while unlocked |

## Verification
A wrong hit or miss count shows at `lock_n` at the evaluation point of the frame where the count matters. The effect is either a lock one frame early or late, or a drop after fewer or more than four misses. A phase counter that does not slip leaves a one-bit-late stream unlocked indefinitely. This is visible as `lock_n` still high at the end of the fourth frame. A false-lock flag that sets or clears at the wrong frame moves the lock edge by whole frames. A reversed payload order shows in the first strobed word.

// File: rtl/fdl_pkg.sv
package fdl_pkg;

    typedef enum logic [1:0] {
        ST_HUNT    = 2'd0,
        ST_CONFIRM = 2'd1,
        ST_LOCKED  = 2'd2
    } fdl_state_e;

endpackage

// File: rtl/fdl_window.sv
module fdl_window #(
    parameter int FRAME_W = 12
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bit_in,
    output logic [FRAME_W-1:0] window
);
    logic [FRAME_W-2:0] hist_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hist_q <= '0;
        end else begin
            hist_q <= {hist_q[FRAME_W-3:0], bit_in};
        end
    end

    // oldest bit at the MSB, the bit arriving this cycle at the LSB
    assign window = {hist_q, bit_in};
endmodule

// File: rtl/fdl_phase.sv
module fdl_phase #(
    parameter int FRAME_W = 12
) (
    input  logic clk,
    input  logic rst_n,
    input  logic slip,
    output logic tick
);
    localparam int PH_W = $clog2(FRAME_W);
    localparam logic [PH_W-1:0] LAST = PH_W'(FRAME_W - 1);

    logic [PH_W-1:0] ph_q;

    assign tick = (ph_q == LAST);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph_q <= '0;
        end else if (tick) begin
            ph_q <= slip ? LAST : '0;
        end else begin
            ph_q <= ph_q + 1'b1;
        end
    end
endmodule

// File: rtl/fdl_rmt_guard.sv
module fdl_rmt_guard #(
    parameter int FRAME_W = 12
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tick,
    input  logic [FRAME_W-1:0] window,
    output logic               block
);
    localparam int RC_W = $clog2(FRAME_W);

    logic [FRAME_W-2:0] rise;
    logic [RC_W-1:0]    rise_cnt;
    logic               multi;
    logic               prev_multi_q;

    for (genvar i = 0; i < FRAME_W - 1; i++) begin : g_rise
        assign rise[i] = ~window[i+1] & window[i];
    end

    always_comb begin
        rise_cnt = '0;
        for (int i = 0; i < FRAME_W - 1; i++) begin
            rise_cnt = rise_cnt + RC_W'(rise[i]);
        end
    end

    assign multi = (rise_cnt >= RC_W'(2));
    assign block = multi & prev_multi_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_multi_q <= 1'b0;
        end else if (tick) begin
            prev_multi_q <= multi;
        end
    end
endmodule

// File: rtl/frame_lock_detector.sv
module frame_lock_detector
    import fdl_pkg::*;
#(
    parameter int DATA_W      = 10,
    parameter int LOCK_HITS   = 4,
    parameter int LOSS_MISSES = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ser_bit,
    output logic              lock_n,
    output logic              out_en,
    output logic              word_vld,
    output logic [DATA_W-1:0] word_out
);
    localparam int FRAME_W = DATA_W + 2;
    localparam int HIT_W   = $clog2(LOCK_HITS + 1);
    localparam int MISS_W  = $clog2(LOSS_MISSES + 1);

    logic [FRAME_W-1:0] window;
    logic               tick;
    logic               slip;
    logic               block;
    logic               hit;
    logic               take;

    fdl_state_e         state_q, state_d;
    logic [HIT_W-1:0]   hits_q, hits_d;
    logic [MISS_W-1:0]  miss_q, miss_d;
    logic [DATA_W-1:0]  word_q;
    logic               vld_q;
    logic               lock_n_q;

    fdl_window #(.FRAME_W(FRAME_W)) u_window (
        .clk    (clk),
        .rst_n  (rst_n),
        .bit_in (ser_bit),
        .window (window)
    );

    fdl_phase #(.FRAME_W(FRAME_W)) u_phase (
        .clk   (clk),
        .rst_n (rst_n),
        .slip  (slip),
        .tick  (tick)
    );

    fdl_rmt_guard #(.FRAME_W(FRAME_W)) u_guard (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick   (tick),
        .window (window),
        .block  (block)
    );

    assign hit = window[FRAME_W-1] & ~window[0];

    always_comb begin
        state_d = state_q;
        hits_d  = hits_q;
        miss_d  = miss_q;
        slip    = 1'b0;
        take    = 1'b0;
        if (tick) begin
            unique case (state_q)
                ST_HUNT: begin
                    if (hit) begin
                        state_d = ST_CONFIRM;
                        hits_d  = HIT_W'(1);
                    end else begin
                        slip = 1'b1;
                    end
                end
                ST_CONFIRM: begin
                    if (!hit) begin
                        state_d = ST_HUNT;
                        hits_d  = '0;
                        slip    = 1'b1;
                    end else if (hits_q == HIT_W'(LOCK_HITS - 1)) begin
                        if (!block) begin
                            state_d = ST_LOCKED;
                            hits_d  = '0;
                            miss_d  = '0;
                            take    = 1'b1;
                        end
                    end else begin
                        hits_d = hits_q + 1'b1;
                    end
                end
                ST_LOCKED: begin
                    if (hit) begin
                        miss_d = '0;
                        take   = 1'b1;
                    end else if (miss_q == MISS_W'(LOSS_MISSES - 1)) begin
                        state_d = ST_HUNT;
                        miss_d  = '0;
                        slip    = 1'b1;
                    end else begin
                        miss_d = miss_q + 1'b1;
                        take   = 1'b1;
                    end
                end
                default: begin
                    state_d = ST_HUNT;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_HUNT;
            hits_q  <= '0;
            miss_q  <= '0;
        end else begin
            state_q <= state_d;
            hits_q  <= hits_d;
            miss_q  <= miss_d;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_q   <= '0;
            vld_q    <= 1'b0;
            lock_n_q <= 1'b1;
        end else begin
            vld_q    <= take;
            lock_n_q <= (state_d != ST_LOCKED);
            if (take) begin
                word_q <= window[FRAME_W-2:1];
            end
        end
    end

    assign lock_n   = lock_n_q;
    assign out_en   = (state_q == ST_LOCKED);
    assign word_vld = vld_q;
    assign word_out = out_en ? word_q : '0;
endmodule

// File: rtl/fdl_checker.sv
module fdl_checker #(
    parameter int DATA_W = 10
) (
    input logic              clk,
    input logic              rst_n,
    input logic              lock_n,
    input logic              out_en,
    input logic              word_vld,
    input logic [DATA_W-1:0] word_out
);
    p_enable_inverse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        out_en == !lock_n);

    p_no_strobe_unlocked_r8: assert property (@(posedge clk) disable iff (!rst_n)
        word_vld |-> !lock_n);

    p_zero_word_unlocked_r8: assert property (@(posedge clk) disable iff (!rst_n)
        lock_n |-> (word_out == '0));

    p_first_word_at_lock_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(lock_n) |-> word_vld);

    p_single_cycle_strobe_r6: assert property (@(posedge clk) disable iff (!rst_n)
        word_vld |=> !word_vld);

    p_drop_no_strobe_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lock_n) |-> !word_vld);
endmodule

bind frame_lock_detector fdl_checker #(.DATA_W(DATA_W)) u_fdl_checker (
    .clk      (clk),
    .rst_n    (rst_n),
    .lock_n   (lock_n),
    .out_en   (out_en),
    .word_vld (word_vld),
    .word_out (word_out)
);

// File: tb/frame_lock_detector_test.sv
module frame_lock_detector_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ser_bit = 1'b0;
    logic       lock_n;
    logic       out_en;
    logic       word_vld;
    logic [9:0] word_out;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    frame_lock_detector uut (
        .clk      (clk),
        .rst_n    (rst_n),
        .ser_bit  (ser_bit),
        .lock_n   (lock_n),
        .out_en   (out_en),
        .word_vld (word_vld),
        .word_out (word_out)
    );

    // {start, payload[9:0], stop, exp_lock_n, exp_vld, exp_word[9:0]}
    localparam int NV = 15;
    localparam logic [23:0] VEC [NV] = '{
        {1'b1, 10'h3F0, 1'b0, 1'b1, 1'b0, 10'h000},
        {1'b1, 10'h3E0, 1'b0, 1'b1, 1'b0, 10'h000},
        {1'b1, 10'h3C0, 1'b0, 1'b1, 1'b0, 10'h000},
        {1'b1, 10'h380, 1'b0, 1'b0, 1'b1, 10'h380},
        {1'b1, 10'h300, 1'b0, 1'b0, 1'b1, 10'h300},
        {1'b0, 10'h000, 1'b0, 1'b0, 1'b1, 10'h000},
        {1'b1, 10'h155, 1'b0, 1'b0, 1'b1, 10'h155},
        {1'b0, 10'h000, 1'b0, 1'b0, 1'b1, 10'h000},
        {1'b0, 10'h000, 1'b0, 1'b0, 1'b1, 10'h000},
        {1'b0, 10'h000, 1'b0, 1'b0, 1'b1, 10'h000},
        {1'b0, 10'h000, 1'b0, 1'b1, 1'b0, 10'h000},
        {1'b1, 10'h3F0, 1'b0, 1'b1, 1'b0, 10'h000},
        {1'b1, 10'h3F0, 1'b0, 1'b1, 1'b0, 10'h000},
        {1'b1, 10'h3F0, 1'b0, 1'b1, 1'b0, 10'h000},
        {1'b1, 10'h2AA, 1'b0, 1'b0, 1'b1, 10'h2AA}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic do_reset();
        rst_n   = 1'b0;
        ser_bit = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // sends start, payload MSB first, stop; returns at the negedge after the stop bit's edge
    task automatic send_frame(input logic st, input logic [9:0] pl, input logic sp);
        logic [11:0] f;
        f = {st, pl, sp};
        for (int i = 11; i >= 0; i--) begin
            ser_bit = f[i];
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog: actual running expected finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        // R1: state during reset
        check("R1 lock_n", 32'(lock_n), 32'd1);
        check("R1 out_en", 32'(out_en), 32'd0);
        check("R1 word_vld", 32'(word_vld), 32'd0);
        check("R1 word_out", 32'(word_out), 32'd0);
        rst_n = 1'b1;

        // table: lock (R3), strobes (R6), miss reset by hit and drop (R7), relock
        for (int i = 0; i < NV; i++) begin
            send_frame(VEC[i][23], VEC[i][22:13], VEC[i][12]);
            check("R3/R7 table lock_n", 32'(lock_n), 32'(VEC[i][11]));
            check("R6 table word_vld", 32'(word_vld), 32'(VEC[i][10]));
            check("R2/R8 table word_out", 32'(word_out), 32'(VEC[i][9:0]));
            check("R8 table out_en", 32'(out_en), 32'(!VEC[i][11]));
        end

        // R5: stream one bit late, offset search slips into place
        do_reset();
        ser_bit = 1'b0;
        @(negedge clk);
        for (int i = 0; i < 3; i++) send_frame(1'b1, 10'h3F0, 1'b0);
        check("R5 still searching", 32'(lock_n), 32'd1);
        send_frame(1'b1, 10'h3F0, 1'b0);
        check("R5 locked after slip", 32'(lock_n), 32'd0);
        check("R2 payload order", 32'(word_out), 32'h3F0);

        // R4: a miss during acquisition restarts the count
        do_reset();
        for (int i = 0; i < 3; i++) send_frame(1'b1, 10'h3F0, 1'b0);
        send_frame(1'b0, 10'h000, 1'b0);
        for (int i = 0; i < 3; i++) send_frame(1'b1, 10'h3E0, 1'b0);
        check("R4 three hits after miss", 32'(lock_n), 32'd1);
        send_frame(1'b1, 10'h3E0, 1'b0);
        check("R4 fourth hit after miss", 32'(lock_n), 32'd0);
        check("R4 word", 32'(word_out), 32'h3E0);

        // R9: repeated multi-rise frames hold off lock
        do_reset();
        for (int i = 0; i < 4; i++) send_frame(1'b1, 10'h155, 1'b0);
        check("R9 blocked at fourth hit", 32'(lock_n), 32'd1);
        send_frame(1'b1, 10'h155, 1'b0);
        check("R9 blocked at fifth hit", 32'(lock_n), 32'd1);
        check("R9 no strobe while blocked", 32'(word_vld), 32'd0);
        send_frame(1'b1, 10'h3F0, 1'b0);
        check("R9 lock after clean frame", 32'(lock_n), 32'd0);
        check("R9 word", 32'(word_out), 32'h3F0);

        // R10: multi-rise frames while locked
        for (int i = 0; i < 2; i++) begin
            send_frame(1'b1, 10'h155, 1'b0);
            check("R10 lock held", 32'(lock_n), 32'd0);
            check("R10 word", 32'(word_out), 32'h155);
        end

        // R2/R7: stop bit of 1 is a miss; four of them drop lock
        for (int i = 0; i < 3; i++) send_frame(1'b1, 10'h3F0, 1'b1);
        check("R7 three bad stops", 32'(lock_n), 32'd0);
        send_frame(1'b1, 10'h3F0, 1'b1);
        check("R2 bad stop drops lock", 32'(lock_n), 32'd1);
        check("R8 word zero after drop", 32'(word_out), 32'd0);

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule